// File: doc/BRIEF.md
# Coarse-Fine Delay-Match Search Controller

This block steers a delay-based on-die temperature sensor. Two clock edges travel down two delay lines: an open-loop line whose delay follows temperature and process, and a reference line whose delay is fixed by a locked loop. A bang-bang phase detector compares the two edges. The controller picks a buffer tap and an interpolator phase on one line, so that its edge lines up with the edge of the other line, and reports the match as one packed code.

A search is a linear coarse sweep over buffer taps with the interpolator at phase 0, which stops on the first tap where the swept edge no longer leads. It is followed by a linear fine sweep of the eight interpolator phases, starting from the last tap that still led. After every tap or phase change the controller waits a set number of settle cycles before it samples the detector. In calibration mode the reference line is held at a setting given from outside, and the sweep runs over the open-loop line. A good result is kept as the open-loop setting for every later measurement. In measurement mode the open-loop line is held at that stored setting, and the sweep runs over the reference line. The result is the temperature code, and a running average of a set number of these codes gives one output sample.

Top module: `dly_match_ctrl`

## Requirements
- R1: After reset, busy_o, conv_done_o, oor_o and avg_done_o are 0, and code_o, avg_code_o, open_tap_o and ref_tap_o are 0.
- R2: A start_i pulse seen while idle begins a search on the swept line with buffer tap 1 and phase 0. Each coarse step raises the tap by exactly one, with the phase held at 0.
- R3: After each tap or phase change, the detector is sampled SETTLE+1 cycles later (default 2). With a target delay of T fine units, a search that finds tap b and needs f fine samples raises conv_done_o 2*(b+f)+1 clock edges after the start edge, counting that edge.
- R4: The detector input pd_early_i is 1 while the swept delay 8*tap+phase is below the fixed delay. The result code is 8*tap+phase at the first fine phase where the detector reads 0. If phase 7 still reads 1, the code is 8*(tap+1). An in-range target T therefore gives the code T.
- R5: Each interpolator word is 16 bits. Bits 7:0 are a thermometer word with its low j bits set for phase j, and bits 15:8 are their bitwise inverse, so exactly 8 drivers are on.
- R6: In calibration mode the reference tap and phase outputs equal ref_cal_i[7:3] and ref_cal_i[2:0]. A result that is not out of range is stored as the open-loop setting.
- R7: In measurement mode open_tap_o and the phase of open_mix_o equal the stored calibration code for the whole search, and the sweep runs over the reference taps 1 to 31.
- R8: If the swept edge still leads at the last tap (511 in calibration, 31 in measurement), the search ends with oor_o high and code_o saturated to 4095 or 255. An out-of-range calibration leaves the stored setting unchanged.
- R9: Every AVG_N (default 100) measurement results, and no calibration results, avg_done_o pulses for one cycle one edge after the last conv_done_o. avg_code_o is the sum divided by AVG_N, with halves rounded up. The sum then restarts from zero.
- R10: A start_i pulse that arrives while a search is running is ignored. It changes neither the timing nor the result.
- R11: conv_done_o is a single-cycle pulse. busy_o is low in that cycle, and code_o and oor_o hold until the next search ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a search when idle |
| cal_mode_i | input | 1 | 1 selects calibration, 0 measurement; sampled on start |
| pd_early_i | input | 1 | Phase detector: 1 while the swept edge leads the fixed edge |
| ref_cal_i | input | 8 | Fixed reference setting used during calibration |
| open_tap_o | output | 9 | Open-loop line buffer tap |
| open_mix_o | output | 16 | Open-loop interpolator driver enables |
| ref_tap_o | output | 5 | Reference line buffer tap |
| ref_mix_o | output | 16 | Reference interpolator driver enables |
| busy_o | output | 1 | Search running |
| conv_done_o | output | 1 | One-cycle pulse at the end of a search |
| oor_o | output | 1 | Last search ran off the end of the line |
| code_o | output | 12 | Last search result, 8*tap+phase |
| avg_done_o | output | 1 | One-cycle pulse when an averaged sample is ready |
| avg_code_o | output | 12 | Rounded average of the last AVG_N measurement codes |

## Verification
The bench models both delay lines and a detector that lags the tap outputs by one register, so a controller that samples before the settle window ends picks up a stale decision and reports the wrong code and cycle count. Directed targets of 0, exact multiples of 8, the last in-range tap and one past it exercise the cases that break easily: a fine sweep that wraps past phase 7 would return a code 8 too low, and a missing saturation would report a code from beyond the line or overwrite the stored calibration. The averaging blocks include a result set whose mean sits exactly on a half, which exposes truncating division. Calibration runs placed inside an averaging block expose an averager that counts the wrong results. A start pulse in the middle of a search checks that the sweep is not restarted.

// File: rtl/dms_pkg.sv
package dms_pkg;
  typedef enum logic [1:0] {
    SRCH_IDLE,
    SRCH_COARSE,
    SRCH_FINE
  } srch_state_e;
endpackage

// File: rtl/dms_mix_enc.sv
module dms_mix_enc #(
  parameter int FW = 3
) (
  input  logic [FW-1:0]        fine_i,
  output logic [(2<<FW)-1:0]   mix_o
);
  localparam int NPH = 1 << FW;

  logic [NPH-1:0] late_en;

  // late_en[i]: driver i fed from the later phase
  for (genvar i = 0; i < NPH; i++) begin : g_therm
    assign late_en[i] = (32'(fine_i) > i);
  end

  assign mix_o = {~late_en, late_en};
endmodule

// File: rtl/dms_search.sv
module dms_search
  import dms_pkg::*;
#(
  parameter int TW     = 9,
  parameter int FW     = 3,
  parameter int SETTLE = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [TW-1:0]    last_tap_i,
  input  logic             pd_i,
  output logic             busy_o,
  output logic [TW-1:0]    tap_o,
  output logic [FW-1:0]    fine_o,
  output logic             done_o,
  output logic             oor_o,
  output logic [TW+FW-1:0] code_o
);
  localparam int SW = (SETTLE > 0) ? $clog2(SETTLE + 1) : 1;
  localparam logic [FW-1:0] FMAX = '1;

  srch_state_e      state_q;
  logic [TW-1:0]    tap_q;
  logic [FW-1:0]    fine_q;
  logic [SW-1:0]    cnt_q;
  logic             done_q, oor_q;
  logic [TW+FW-1:0] code_q;
  logic             sample;

  assign sample = (cnt_q == SW'(SETTLE));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SRCH_IDLE;
      tap_q   <= '0;
      fine_q  <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      oor_q   <= 1'b0;
      code_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        SRCH_IDLE: begin
          if (start_i) begin
            tap_q   <= TW'(1);
            fine_q  <= '0;
            cnt_q   <= '0;
            oor_q   <= 1'b0;
            state_q <= SRCH_COARSE;
          end
        end
        SRCH_COARSE: begin
          if (!sample) begin
            cnt_q <= cnt_q + SW'(1);
          end else begin
            cnt_q <= '0;
            if (!pd_i) begin
              // back off to the last tap that still led
              tap_q   <= tap_q - TW'(1);
              fine_q  <= '0;
              state_q <= SRCH_FINE;
            end else if (tap_q == last_tap_i) begin
              done_q  <= 1'b1;
              oor_q   <= 1'b1;
              code_q  <= {last_tap_i, FMAX};
              state_q <= SRCH_IDLE;
            end else begin
              tap_q <= tap_q + TW'(1);
            end
          end
        end
        SRCH_FINE: begin
          if (!sample) begin
            cnt_q <= cnt_q + SW'(1);
          end else begin
            cnt_q <= '0;
            if (!pd_i) begin
              done_q  <= 1'b1;
              code_q  <= {tap_q, fine_q};
              state_q <= SRCH_IDLE;
            end else if (fine_q == FMAX) begin
              // next position is the next tap, already known late
              done_q  <= 1'b1;
              code_q  <= {tap_q + TW'(1), {FW{1'b0}}};
              state_q <= SRCH_IDLE;
            end else begin
              fine_q <= fine_q + FW'(1);
            end
          end
        end
        default: state_q <= SRCH_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != SRCH_IDLE);
  assign tap_o  = tap_q;
  assign fine_o = fine_q;
  assign done_o = done_q;
  assign oor_o  = oor_q;
  assign code_o = code_q;
endmodule

// File: rtl/dms_avg.sv
module dms_avg #(
  parameter int N  = 100,
  parameter int CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_vld_i,
  input  logic [CW-1:0] in_code_i,
  output logic          done_o,
  output logic [CW-1:0] avg_o
);
  localparam int SUMW = $clog2(N * ((1 << CW) - 1) + N / 2 + 1);
  localparam int NW   = (N > 1) ? $clog2(N) : 1;

  logic [SUMW-1:0] sum_q, sum_nxt, rnd;
  logic [NW-1:0]   cnt_q;
  logic            done_q;
  logic [CW-1:0]   avg_q;

  assign sum_nxt = sum_q + SUMW'(in_code_i);
  assign rnd     = (sum_nxt + SUMW'(N / 2)) / SUMW'(N);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      avg_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (in_vld_i) begin
        if (cnt_q == NW'(N - 1)) begin
          avg_q  <= rnd[CW-1:0];
          done_q <= 1'b1;
          sum_q  <= '0;
          cnt_q  <= '0;
        end else begin
          sum_q <= sum_nxt;
          cnt_q <= cnt_q + NW'(1);
        end
      end
    end
  end

  assign done_o = done_q;
  assign avg_o  = avg_q;
endmodule

// File: rtl/dly_match_ctrl.sv
module dly_match_ctrl #(
  parameter int OPEN_TAPS = 512,
  parameter int REF_TAPS  = 32,
  parameter int FINE_BITS = 3,
  parameter int SETTLE    = 1,
  parameter int AVG_N     = 100
) (
  input  logic                                        clk_i,
  input  logic                                        rst_ni,
  input  logic                                        start_i,
  input  logic                                        cal_mode_i,
  input  logic                                        pd_early_i,
  input  logic [$clog2(REF_TAPS)+FINE_BITS-1:0]       ref_cal_i,
  output logic [$clog2(OPEN_TAPS)-1:0]                open_tap_o,
  output logic [(2<<FINE_BITS)-1:0]                   open_mix_o,
  output logic [$clog2(REF_TAPS)-1:0]                 ref_tap_o,
  output logic [(2<<FINE_BITS)-1:0]                   ref_mix_o,
  output logic                                        busy_o,
  output logic                                        conv_done_o,
  output logic                                        oor_o,
  output logic [$clog2(OPEN_TAPS)+FINE_BITS-1:0]      code_o,
  output logic                                        avg_done_o,
  output logic [$clog2(OPEN_TAPS)+FINE_BITS-1:0]      avg_code_o
);
  localparam int OTW = $clog2(OPEN_TAPS);
  localparam int RTW = $clog2(REF_TAPS);
  localparam int FB  = FINE_BITS;
  localparam int OCW = OTW + FB;
  localparam int RCW = RTW + FB;

  logic           mode_q;   // 1: calibration
  logic [OCW-1:0] cal_q;
  logic           s_busy, s_done, s_oor;
  logic [OTW-1:0] s_tap, last_tap;
  logic [FB-1:0]  s_fine, open_fine, ref_fine;
  logic [OCW-1:0] s_code;

  assign last_tap = mode_q ? OTW'(OPEN_TAPS - 1) : OTW'(REF_TAPS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      cal_q  <= '0;
    end else begin
      if (start_i && !s_busy) mode_q <= cal_mode_i;
      if (s_done && mode_q && !s_oor) cal_q <= s_code;
    end
  end

  dms_search #(
    .TW(OTW), .FW(FB), .SETTLE(SETTLE)
  ) u_search (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .last_tap_i (last_tap),
    .pd_i       (pd_early_i),
    .busy_o     (s_busy),
    .tap_o      (s_tap),
    .fine_o     (s_fine),
    .done_o     (s_done),
    .oor_o      (s_oor),
    .code_o     (s_code)
  );

  assign open_tap_o = mode_q ? s_tap  : cal_q[OCW-1:FB];
  assign open_fine  = mode_q ? s_fine : cal_q[FB-1:0];
  assign ref_tap_o  = mode_q ? ref_cal_i[RCW-1:FB] : s_tap[RTW-1:0];
  assign ref_fine   = mode_q ? ref_cal_i[FB-1:0]   : s_fine;

  dms_mix_enc #(.FW(FB)) u_open_mix (.fine_i(open_fine), .mix_o(open_mix_o));
  dms_mix_enc #(.FW(FB)) u_ref_mix  (.fine_i(ref_fine),  .mix_o(ref_mix_o));

  dms_avg #(.N(AVG_N), .CW(OCW)) u_avg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .in_vld_i  (s_done && !mode_q),
    .in_code_i (s_code),
    .done_o    (avg_done_o),
    .avg_o     (avg_code_o)
  );

  assign busy_o      = s_busy;
  assign conv_done_o = s_done;
  assign oor_o       = s_oor;
  assign code_o      = s_code;
endmodule

// File: rtl/dly_match_ctrl_chk.sv
module dly_match_ctrl_chk #(
  parameter int OPEN_TAPS = 512,
  parameter int REF_TAPS  = 32,
  parameter int FINE_BITS = 3
) (
  input logic                                   clk_i,
  input logic                                   rst_ni,
  input logic                                   mode_q,
  input logic [$clog2(OPEN_TAPS)+FINE_BITS-1:0] cal_q,
  input logic                                   busy_o,
  input logic                                   conv_done_o,
  input logic                                   oor_o,
  input logic [$clog2(OPEN_TAPS)+FINE_BITS-1:0] code_o,
  input logic [$clog2(OPEN_TAPS)-1:0]           open_tap_o,
  input logic [(2<<FINE_BITS)-1:0]              open_mix_o,
  input logic [$clog2(REF_TAPS)-1:0]            ref_tap_o,
  input logic [(2<<FINE_BITS)-1:0]              ref_mix_o,
  input logic [$clog2(REF_TAPS)+FINE_BITS-1:0]  ref_cal_i,
  input logic                                   avg_done_o
);
  localparam int OTW = $clog2(OPEN_TAPS);
  localparam int FB  = FINE_BITS;
  localparam int NPH = 1 << FB;
  localparam int OCW = OTW + FB;

  logic [NPH-1:0] ol, rl;
  assign ol = open_mix_o[NPH-1:0];
  assign rl = ref_mix_o[NPH-1:0];

  assert_open_mix_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(open_mix_o) == NPH && open_mix_o[2*NPH-1:NPH] == ~ol && (ol & (ol + NPH'(1))) == '0);
  assert_ref_mix_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(ref_mix_o) == NPH && ref_mix_o[2*NPH-1:NPH] == ~rl && (rl & (rl + NPH'(1))) == '0);
  assert_ref_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && mode_q |-> ref_tap_o == ref_cal_i[$bits(ref_cal_i)-1:FB]);
  assert_cal_store_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_done_o && mode_q && !oor_o |=> cal_q == $past(code_o));
  assert_open_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !mode_q |-> open_tap_o == cal_q[OCW-1:FB]);
  assert_tap_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) && mode_q |->
      (open_tap_o == $past(open_tap_o) || open_tap_o == $past(open_tap_o) + OTW'(1) ||
       open_tap_o == $past(open_tap_o) - OTW'(1)));
  assert_oor_sat_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_done_o && oor_o |-> code_o == (mode_q ? OCW'(OPEN_TAPS * NPH - 1) : OCW'(REF_TAPS * NPH - 1)));
  assert_oor_keep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_done_o && oor_o && mode_q |=> cal_q == $past(cal_q));
  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_done_o |=> !conv_done_o);
  assert_done_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_done_o |-> !busy_o);
  assert_avg_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avg_done_o |=> !avg_done_o);
endmodule

bind dly_match_ctrl dly_match_ctrl_chk #(
  .OPEN_TAPS(OPEN_TAPS), .REF_TAPS(REF_TAPS), .FINE_BITS(FINE_BITS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_q      (mode_q),
  .cal_q       (cal_q),
  .busy_o      (busy_o),
  .conv_done_o (conv_done_o),
  .oor_o       (oor_o),
  .code_o      (code_o),
  .open_tap_o  (open_tap_o),
  .open_mix_o  (open_mix_o),
  .ref_tap_o   (ref_tap_o),
  .ref_mix_o   (ref_mix_o),
  .ref_cal_i   (ref_cal_i),
  .avg_done_o  (avg_done_o)
);

// File: tb/dly_match_ctrl_tb.sv
`timescale 1ns/1ps
module dly_match_ctrl_tb;
  localparam int OPEN_TAPS = 512;
  localparam int REF_TAPS  = 32;
  localparam int FB        = 3;
  localparam int AVG_N     = 100;
  localparam int NPH       = 1 << FB;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        cal_mode = 1'b0;
  logic        pd_q = 1'b0;
  logic [7:0]  ref_cal = 8'd150;
  logic [8:0]  open_tap;
  logic [15:0] open_mix, ref_mix;
  logic [4:0]  ref_tap;
  logic        busy, conv_done, oor, avg_done;
  logic [11:0] code, avg_code;

  int total = 0, bad = 0;
  int fixed_dly = 0;     // delay of the line not being swept
  bit mode_b = 1'b0;
  int cal_exp = 0;       // stored open-loop setting
  int acc_sum = 0, acc_cnt = 0;

  always #2.5 clk = ~clk;

  dly_match_ctrl #(
    .OPEN_TAPS(OPEN_TAPS), .REF_TAPS(REF_TAPS), .FINE_BITS(FB), .SETTLE(1), .AVG_N(AVG_N)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cal_mode_i(cal_mode),
    .pd_early_i(pd_q), .ref_cal_i(ref_cal),
    .open_tap_o(open_tap), .open_mix_o(open_mix), .ref_tap_o(ref_tap), .ref_mix_o(ref_mix),
    .busy_o(busy), .conv_done_o(conv_done), .oor_o(oor), .code_o(code),
    .avg_done_o(avg_done), .avg_code_o(avg_code)
  );

  // delay-line and detector model: one register of lag after the taps
  always_ff @(posedge clk) begin
    if (mode_b) pd_q <= (int'(open_tap) * NPH + $countones(open_mix[NPH-1:0])) < fixed_dly;
    else        pd_q <= (int'(ref_tap) * NPH + $countones(ref_mix[NPH-1:0])) < fixed_dly;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit mix_ok(input logic [15:0] m);
    logic [7:0] lo;
    lo = m[7:0];
    return (m[15:8] == ~lo) && ((lo & (lo + 8'd1)) == 8'd0);
  endfunction

  function automatic void model(input bit cal, input int tgt, output int c, output bit o, output int cyc);
    int last, bf, j, f;
    last = cal ? OPEN_TAPS - 1 : REF_TAPS - 1;
    if (tgt > NPH * last) begin
      c = NPH * last + NPH - 1; o = 1'b1; cyc = 2 * last + 1;
    end else begin
      bf = (tgt + NPH - 1) / NPH;
      if (bf < 1) bf = 1;
      j = tgt - NPH * (bf - 1);
      f = (j <= NPH - 1) ? j + 1 : NPH;
      c = tgt; o = 1'b0; cyc = 2 * (bf + f) + 1;
    end
  endfunction

  task automatic run_conv(input bit cal, input int tgt, input bit poke);
    int ec, ecyc, n;
    bit eo;
    model(cal, tgt, ec, eo, ecyc);
    @(negedge clk);
    cal_mode = cal; mode_b = cal; fixed_dly = tgt; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    n = 1;
    chk(busy == 1'b1, "R11", "busy after start", int'(busy), 1);
    if (cal) begin
      chk(open_tap == 9'd1 && open_mix[7:0] == 8'd0, "R2", "first open tap", int'(open_tap), 1);
      chk(ref_tap == ref_cal[7:3] && $countones(ref_mix[7:0]) == int'(ref_cal[2:0]), "R6", "ref held",
          int'(ref_tap), int'(ref_cal[7:3]));
    end else begin
      chk(ref_tap == 5'd1 && ref_mix[7:0] == 8'd0, "R2", "first ref tap", int'(ref_tap), 1);
      chk(int'(open_tap) * NPH + $countones(open_mix[7:0]) == cal_exp, "R7", "open held",
          int'(open_tap) * NPH + $countones(open_mix[7:0]), cal_exp);
    end
    while (!conv_done && n < 3000) begin
      if (poke && n == 3) start = 1'b1; else start = 1'b0;
      @(posedge clk);
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    chk(n == ecyc, "R3", "conversion edges", n, ecyc);
    chk(int'(code) == ec, "R4", "result code", int'(code), ec);
    chk(oor == eo, "R8", "out-of-range flag", int'(oor), int'(eo));
    chk(busy == 1'b0, "R11", "busy at done", int'(busy), 0);
    chk(mix_ok(open_mix) && mix_ok(ref_mix), "R5", "mix words", int'(open_mix), int'(ref_mix));
    if (poke) chk(n == ecyc && int'(code) == ec, "R10", "start while busy", int'(code), ec);
    if (cal && !eo) cal_exp = ec;
    if (!cal) begin
      acc_sum += ec;
      acc_cnt++;
    end
    @(posedge clk);
    @(negedge clk);
    chk(conv_done == 1'b0 && int'(code) == ec, "R11", "done pulse width", int'(conv_done), 0);
    if (!cal && acc_cnt == AVG_N) begin
      chk(avg_done == 1'b1, "R9", "avg strobe", int'(avg_done), 1);
      chk(int'(avg_code) == (acc_sum + AVG_N / 2) / AVG_N, "R9", "avg value",
          int'(avg_code), (acc_sum + AVG_N / 2) / AVG_N);
      acc_sum = 0; acc_cnt = 0;
    end else begin
      chk(avg_done == 1'b0, "R9", "no avg strobe", int'(avg_done), 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    chk(busy == 0 && conv_done == 0 && oor == 0 && avg_done == 0, "R1", "reset flags",
        int'({busy, conv_done, oor, avg_done}), 0);
    chk(code == 0 && avg_code == 0 && open_tap == 0 && ref_tap == 0, "R1", "reset values",
        int'(code) + int'(avg_code) + int'(open_tap) + int'(ref_tap), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // calibration corners
    run_conv(1'b1, 0, 1'b0);
    run_conv(1'b1, 8, 1'b0);      // fine sweep runs past phase 7
    run_conv(1'b1, 13, 1'b0);
    run_conv(1'b1, 4095, 1'b0);   // off the end, R8 keeps setting 13
    run_conv(1'b0, 50, 1'b0);     // R7 checks open held at 13
    run_conv(1'b1, 4088, 1'b0);   // last in-range tap
    run_conv(1'b1, 777, 1'b1);    // R10 start poke

    // measurement corners
    run_conv(1'b0, 0, 1'b0);
    run_conv(1'b0, 248, 1'b0);
    run_conv(1'b0, 249, 1'b0);
    run_conv(1'b0, 255, 1'b1);

    // random mix, calibration runs inside averaging blocks
    for (int i = 0; i < 160; i++) begin
      if (i % 37 == 20) run_conv(1'b1, int'($urandom_range(0, 4100)), 1'b0);
      run_conv(1'b0, int'($urandom_range(0, 260)), (i % 11) == 0);
    end
    while (acc_cnt != 0) run_conv(1'b0, 0, 1'b0);

    // R9 rounding: mean 10.5 rounds up to 11
    for (int i = 0; i < AVG_N; i++) run_conv(1'b0, (i < AVG_N / 2) ? 10 : 11, 1'b0);
    chk(int'(avg_code) == 11, "R9", "half rounds up", int'(avg_code), 11);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule